// File: doc/BRIEF.md
# Three-Voice Synthesizer Host Register Port

This block is the byte-wide host side of a three-voice sound generator. A host writes bytes through a 5-bit address. The block decodes each write into one of several registers and presents them as parallel outputs to the oscillator, envelope and filter datapaths, which sit outside it. Each voice has a frequency, pulse width, control, attack/decay and sustain/release register. The filter has cutoff, resonance, routing, mode and volume fields.

Only a few addresses can be read back. One gives the third voice's oscillator value, one gives its envelope value, and two always read zero. A read of any write-only address returns the last byte written to any address. That stored byte has a fixed lifetime, measured in sound-cycle enables, after which it clears to zero. The block also closes the three voices into a cyclic hard-sync ring. For each voice it produces a sync-reset strobe from the voices' most-significant-bit rise flags and their sync control bits.

Top module: `sndbus_top`

## Requirements
- R1: Voice v (0..2) owns addresses 7*v to 7*v+6. The offsets, in order, are: frequency low byte, frequency high byte, pulse width low byte, pulse width high nibble (bits [3:0] of the byte only), control, attack/decay and sustain/release. They drive `voiceFreq[v]` (16 bits), `voicePw[v]` (12 bits), `voiceCtrl[v]`, `voiceAd[v]` and `voiceSr[v]`.
- R2: A write to 0x15 sets cutoff bits [2:0] from data bits [2:0]. A write to 0x16 sets cutoff bits [10:3] from the whole byte. Neither write disturbs the other part.
- R3: A write to 0x17 sets `resonance` from bits [7:4] and `routeMask` from bits [3:0]. A write to 0x18 sets `voice3Off` from bit 7, `filtMode` from bits [6:4] and `volume` from bits [3:0].
- R4: A control write stores the full byte in `voiceCtrl[v]`. Bit 0 of that byte appears as the envelope gate `voiceGate[v]`.
- R5: Reads of 0x19 and 0x1A return 0x00. A read of 0x1B returns `osc3In`, and a read of 0x1C returns `env3In`.
- R6: Every write stores its byte as the bus value and reloads the lifetime to 0x2000. Reads of 0x00-0x18 and 0x1D-0x1F return the bus value.
- R7: The lifetime drops by one on each cycle with `cycleEn` high and no write. The bus value still reads back after 0x1FFF such cycles and reads 0x00 after 0x2000. A write in the same cycle as `cycleEn` wins.
- R8: `rdData` is loaded on the clock edge where `rdEn` is high and holds its value otherwise. A read and a write in the same cycle return the bus value from before the write.
- R9: Writes to 0x19-0x1F change no register output but still refresh the bus value and its lifetime.
- R10: The sync source of voice 0 is voice 2, of voice 1 is voice 0, and of voice 2 is voice 1. `syncReset[v]` is high when the source's `msbRise` bit is high and `voiceCtrl[v]` bit 1 is set. The exception is when the source itself has its bit 1 set and its own source's `msbRise` bit is high in the same cycle.
- R11: After reset, every register output, the bus value and `rdData` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycleEn | input | 1 | Sound-cycle enable that ages the bus value |
| addr | input | 5 | Register address |
| wrData | input | 8 | Write byte |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Registered read byte |
| osc3In | input | 8 | Voice 2 oscillator read-back |
| env3In | input | 8 | Voice 2 envelope value |
| msbRise | input | 3 | Per-voice accumulator MSB rise flags |
| voiceFreq | output | 3x16 | Per-voice frequency |
| voicePw | output | 3x12 | Per-voice pulse width |
| voiceCtrl | output | 3x8 | Per-voice control byte |
| voiceGate | output | 3 | Per-voice envelope gate |
| voiceAd | output | 3x8 | Per-voice attack/decay |
| voiceSr | output | 3x8 | Per-voice sustain/release |
| syncReset | output | 3 | Per-voice hard-sync reset strobe |
| cutoff | output | 11 | Filter cutoff |
| resonance | output | 4 | Filter resonance |
| routeMask | output | 4 | Filter routing mask |
| voice3Off | output | 1 | Voice 2 mute flag |
| filtMode | output | 3 | Filter mode |
| volume | output | 4 | Master volume |

## Verification
A table of writes covers every voice slot type, including both halves of the frequency and pulse width. It also covers all four filter addresses, each followed by a check of the field it should reach. This shows up a swapped slot order, a wrong voice base or a misplaced bit field.

The aging test stops one enable short of expiry and then one enable past it, which catches an off-by-one lifetime. A same-cycle read/write and a write to an unused address tell apart read ordering and refresh-without-effect. The sync patterns compare a plain source rise with a source that is itself being reset in the same cycle.

// File: rtl/sndbus_pkg.sv
package sndbus_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 5;
  localparam int NUM_VOICES = 3;
  localparam int REGS_PER_VOICE = 7;
  localparam int FREQ_W = 2 * DATA_W;
  localparam int PW_W = 12;
  localparam int CUT_LO_W = 3;
  localparam int CUT_W = CUT_LO_W + DATA_W;
  localparam int FILT_BASE = NUM_VOICES * REGS_PER_VOICE;
  localparam int NUM_FILT_REGS = 4;
  localparam int ZERO_A = FILT_BASE + NUM_FILT_REGS;
  localparam int ZERO_B = ZERO_A + 1;
  localparam int OSC_RD = ZERO_A + 2;
  localparam int ENV_RD = ZERO_A + 3;

  typedef enum logic [2:0] {
    SLOT_FLO, SLOT_FHI, SLOT_PLO, SLOT_PHI, SLOT_CTRL, SLOT_AD, SLOT_SR, SLOT_NONE
  } slot_e;

  typedef enum logic [1:0] {RD_BUS, RD_ZERO, RD_OSC, RD_ENV} rdsel_e;

  typedef struct packed {
    logic                     wrAny;
    logic [NUM_VOICES-1:0]    voiceSel;
    slot_e                    slot;
    logic [NUM_FILT_REGS-1:0] filtSel;
    logic                     rdEn;
    rdsel_e                   rdSel;
  } strobe_t;
endpackage

// File: rtl/sndbus_ctrl.sv
module sndbus_ctrl
  import sndbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobe_t           st
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    st.wrAny    = wrEn;
    st.rdEn     = rdEn;
    st.voiceSel = '0;
    offset      = ADDR_W'(REGS_PER_VOICE);
    for (int v = 0; v < NUM_VOICES; v++) begin
      if (addr >= ADDR_W'(v * REGS_PER_VOICE) && addr < ADDR_W'((v + 1) * REGS_PER_VOICE)) begin
        st.voiceSel[v] = wrEn;
        offset = addr - ADDR_W'(v * REGS_PER_VOICE);
      end
    end
    st.slot = slot_e'(offset[2:0]);
  end

  for (genvar k = 0; k < NUM_FILT_REGS; k++) begin : g_filt
    assign st.filtSel[k] = wrEn && (addr == ADDR_W'(FILT_BASE + k));
  end

  always_comb begin
    case (addr)
      ADDR_W'(ZERO_A), ADDR_W'(ZERO_B): st.rdSel = RD_ZERO;
      ADDR_W'(OSC_RD):                  st.rdSel = RD_OSC;
      ADDR_W'(ENV_RD):                  st.rdSel = RD_ENV;
      default:                          st.rdSel = RD_BUS;
    endcase
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({st.voiceSel, st.filtSel}) <= 1); // R1
  AST_NO_WRITE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |-> (st.voiceSel == '0 && st.filtSel == '0)); // R9
endmodule

// File: rtl/sndbus_data.sv
module sndbus_data
  import sndbus_pkg::*;
#(
  parameter int LIFE_CYCLES = 'h2000
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cycleEn,
  input  strobe_t                             st,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic [DATA_W-1:0]                   osc3In,
  input  logic [DATA_W-1:0]                   env3In,
  input  logic [NUM_VOICES-1:0]               msbRise,
  output logic [DATA_W-1:0]                   rdData,
  output logic [NUM_VOICES-1:0][FREQ_W-1:0]   voiceFreq,
  output logic [NUM_VOICES-1:0][PW_W-1:0]     voicePw,
  output logic [NUM_VOICES-1:0][DATA_W-1:0]   voiceCtrl,
  output logic [NUM_VOICES-1:0]               voiceGate,
  output logic [NUM_VOICES-1:0][DATA_W-1:0]   voiceAd,
  output logic [NUM_VOICES-1:0][DATA_W-1:0]   voiceSr,
  output logic [NUM_VOICES-1:0]               syncReset,
  output logic [CUT_W-1:0]                    cutoff,
  output logic [3:0]                          resonance,
  output logic [3:0]                          routeMask,
  output logic                                voice3Off,
  output logic [2:0]                          filtMode,
  output logic [3:0]                          volume
);
  localparam int LIFE_W = $clog2(LIFE_CYCLES + 1);
  localparam logic [LIFE_W-1:0] LIFE_LOAD = LIFE_W'(LIFE_CYCLES);

  logic [DATA_W-1:0] busVal;
  logic [LIFE_W-1:0] life;

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
    localparam int SRC  = (v + NUM_VOICES - 1) % NUM_VOICES;
    localparam int SRC2 = (v + 2 * NUM_VOICES - 2) % NUM_VOICES;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        voiceFreq[v] <= '0;
        voicePw[v]   <= '0;
        voiceCtrl[v] <= '0;
        voiceAd[v]   <= '0;
        voiceSr[v]   <= '0;
      end else if (st.voiceSel[v]) begin
        case (st.slot)
          SLOT_FLO:  voiceFreq[v][DATA_W-1:0]      <= wrData;
          SLOT_FHI:  voiceFreq[v][FREQ_W-1:DATA_W] <= wrData;
          SLOT_PLO:  voicePw[v][DATA_W-1:0]        <= wrData;
          SLOT_PHI:  voicePw[v][PW_W-1:DATA_W]     <= wrData[PW_W-DATA_W-1:0];
          SLOT_CTRL: voiceCtrl[v]                  <= wrData;
          SLOT_AD:   voiceAd[v]                    <= wrData;
          SLOT_SR:   voiceSr[v]                    <= wrData;
          default:   ;
        endcase
      end
    end

    assign voiceGate[v] = voiceCtrl[v][0];
    assign syncReset[v] = msbRise[SRC] & voiceCtrl[v][1]
                        & ~(voiceCtrl[SRC][1] & msbRise[SRC2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cutoff    <= '0;
      resonance <= '0;
      routeMask <= '0;
      voice3Off <= 1'b0;
      filtMode  <= '0;
      volume    <= '0;
    end else begin
      if (st.filtSel[0]) cutoff[CUT_LO_W-1:0]     <= wrData[CUT_LO_W-1:0];
      if (st.filtSel[1]) cutoff[CUT_W-1:CUT_LO_W] <= wrData;
      if (st.filtSel[2]) begin
        resonance <= wrData[7:4];
        routeMask <= wrData[3:0];
      end
      if (st.filtSel[3]) begin
        voice3Off <= wrData[7];
        filtMode  <= wrData[6:4];
        volume    <= wrData[3:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busVal <= '0;
      life   <= '0;
    end else if (st.wrAny) begin
      busVal <= wrData;
      life   <= LIFE_LOAD;
    end else if (cycleEn && life != '0) begin
      life <= life - 1'b1;
      if (life == LIFE_W'(1)) busVal <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdData <= '0;
    else if (st.rdEn) begin
      case (st.rdSel)
        RD_ZERO: rdData <= '0;
        RD_OSC:  rdData <= osc3In;
        RD_ENV:  rdData <= env3In;
        default: rdData <= busVal;
      endcase
    end
  end

  AST_WRITE_LOADS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    st.wrAny |=> (busVal == $past(wrData) && life == LIFE_LOAD)); // R6
  AST_EXPIRED_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (life == '0) |-> (busVal == '0)); // R7
  AST_LIFE_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!st.wrAny && !cycleEn) |=> $stable(life)); // R7
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !st.rdEn |=> $stable(rdData)); // R8
  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (st.rdEn && st.rdSel == RD_ZERO) |=> rdData == '0); // R5
endmodule

// File: rtl/sndbus_top.sv
module sndbus_top
  import sndbus_pkg::*;
#(
  parameter int LIFE_CYCLES = 'h2000
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cycleEn,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic                                wrEn,
  input  logic                                rdEn,
  output logic [DATA_W-1:0]                   rdData,
  input  logic [DATA_W-1:0]                   osc3In,
  input  logic [DATA_W-1:0]                   env3In,
  input  logic [NUM_VOICES-1:0]               msbRise,
  output logic [NUM_VOICES-1:0][FREQ_W-1:0]   voiceFreq,
  output logic [NUM_VOICES-1:0][PW_W-1:0]     voicePw,
  output logic [NUM_VOICES-1:0][DATA_W-1:0]   voiceCtrl,
  output logic [NUM_VOICES-1:0]               voiceGate,
  output logic [NUM_VOICES-1:0][DATA_W-1:0]   voiceAd,
  output logic [NUM_VOICES-1:0][DATA_W-1:0]   voiceSr,
  output logic [NUM_VOICES-1:0]               syncReset,
  output logic [CUT_W-1:0]                    cutoff,
  output logic [3:0]                          resonance,
  output logic [3:0]                          routeMask,
  output logic                                voice3Off,
  output logic [2:0]                          filtMode,
  output logic [3:0]                          volume
);
  strobe_t st;

  sndbus_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .st(st)
  );

  sndbus_data #(.LIFE_CYCLES(LIFE_CYCLES)) u_data (
    .clk(clk), .rst_n(rst_n), .cycleEn(cycleEn), .st(st), .wrData(wrData),
    .osc3In(osc3In), .env3In(env3In), .msbRise(msbRise), .rdData(rdData),
    .voiceFreq(voiceFreq), .voicePw(voicePw), .voiceCtrl(voiceCtrl),
    .voiceGate(voiceGate), .voiceAd(voiceAd), .voiceSr(voiceSr),
    .syncReset(syncReset), .cutoff(cutoff), .resonance(resonance),
    .routeMask(routeMask), .voice3Off(voice3Off), .filtMode(filtMode),
    .volume(volume)
  );
endmodule

// File: tb/sndbus_top_test.sv
module sndbus_top_test;
  localparam int CLK_NS = 20;
  localparam int LIFE = 'h2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycleEn = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wrData = '0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [7:0] rdData;
  logic [7:0] osc3In = 8'h00;
  logic [7:0] env3In = 8'h00;
  logic [2:0] msbRise = '0;
  logic [2:0][15:0] voiceFreq;
  logic [2:0][11:0] voicePw;
  logic [2:0][7:0] voiceCtrl;
  logic [2:0] voiceGate;
  logic [2:0][7:0] voiceAd;
  logic [2:0][7:0] voiceSr;
  logic [2:0] syncReset;
  logic [10:0] cutoff;
  logic [3:0] resonance, routeMask, volume;
  logic voice3Off;
  logic [2:0] filtMode;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_NS / 2) clk = ~clk;

  sndbus_top #(.LIFE_CYCLES(LIFE)) uut (.*);

  typedef struct packed {
    logic [4:0]  a;
    logic [7:0]  d;
    logic [4:0]  fid;
    logic [15:0] exp;
  } vec_t;

  // fid: voice v field k at v*5+k (freq, pw, ctrl, ad, sr);
  // 15 cutoff, 16 resonance, 17 route, 18 voice3Off, 19 mode, 20 volume
  localparam int NVEC = 16;
  localparam vec_t TBL [NVEC] = '{
    '{5'h00, 8'h34, 5'd0,  16'h0034},  // R1 freq low
    '{5'h01, 8'h12, 5'd0,  16'h1234},  // R1 freq high
    '{5'h03, 8'hFA, 5'd1,  16'h0A00},  // R1 pw high nibble only
    '{5'h02, 8'h55, 5'd1,  16'h0A55},  // R1 pw low
    '{5'h0B, 8'h41, 5'd7,  16'h0041},  // R4 voice1 control
    '{5'h0C, 8'h9C, 5'd8,  16'h009C},  // R1 voice1 a/d
    '{5'h14, 8'h7E, 5'd14, 16'h007E},  // R1 voice2 s/r
    '{5'h0F, 8'hC3, 5'd10, 16'hC300},  // R1 voice2 freq high
    '{5'h15, 8'hFF, 5'd15, 16'h0007},  // R2 cutoff low bits
    '{5'h16, 8'hAB, 5'd15, 16'h055F},  // R2 cutoff high bits
    '{5'h17, 8'hD6, 5'd16, 16'h000D},  // R3 resonance
    '{5'h17, 8'hD6, 5'd17, 16'h0006},  // R3 route
    '{5'h18, 8'hA5, 5'd18, 16'h0001},  // R3 voice3Off
    '{5'h18, 8'hA5, 5'd19, 16'h0002},  // R3 mode
    '{5'h18, 8'hA5, 5'd20, 16'h0005},  // R3 volume
    '{5'h12, 8'h21, 5'd12, 16'h0021}   // R4 voice2 control
  };

  function automatic logic [15:0] field(input logic [4:0] fid);
    if (fid < 15) begin
      case (fid % 5)
        0: return voiceFreq[fid / 5];
        1: return {4'h0, voicePw[fid / 5]};
        2: return {8'h0, voiceCtrl[fid / 5]};
        3: return {8'h0, voiceAd[fid / 5]};
        default: return {8'h0, voiceSr[fid / 5]};
      endcase
    end
    case (fid)
      15: return {5'h0, cutoff};
      16: return {12'h0, resonance};
      17: return {12'h0, routeMask};
      18: return {15'h0, voice3Off};
      19: return {13'h0, filtMode};
      default: return {12'h0, volume};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [4:0] a, output logic [7:0] q);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    q = rdData;
  endtask

  task automatic age(input int n);
    @(negedge clk);
    cycleEn = 1'b1;
    repeat (n) @(negedge clk);
    cycleEn = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 190000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 rdData", {8'h0, rdData}, 16'h0);
    chk("R11 freq", voiceFreq[0], 16'h0);
    chk("R11 volume", {12'h0, volume}, 16'h0);
    rst_n = 1'b1;
    doRead(5'h00, q);
    chk("R11 bus value", {8'h0, q}, 16'h0);

    for (int i = 0; i < NVEC; i++) begin
      doWrite(TBL[i].a, TBL[i].d);
      chk($sformatf("R1/R2/R3/R4 vector %0d", i), field(TBL[i].fid), TBL[i].exp);
    end
    chk("R4 gate", {13'h0, voiceGate}, 16'h0006);

    // R5 readable addresses
    osc3In = 8'h5A; env3In = 8'hC7;
    doRead(5'h1B, q); chk("R5 osc", {8'h0, q}, 16'h005A);
    doRead(5'h1C, q); chk("R5 env", {8'h0, q}, 16'h00C7);
    doRead(5'h19, q); chk("R5 zero 19", {8'h0, q}, 16'h0);
    doRead(5'h1A, q); chk("R5 zero 1A", {8'h0, q}, 16'h0);

    // R6 bus value from write-only addresses
    doWrite(5'h05, 8'h9E);
    doRead(5'h10, q); chk("R6 bus readback", {8'h0, q}, 16'h009E);
    doRead(5'h1F, q); chk("R6 bus readback 1F", {8'h0, q}, 16'h009E);

    // R9 unused-address write refreshes bus, no register effect
    doWrite(5'h1E, 8'h3C);
    chk("R9 volume kept", {12'h0, volume}, 16'h0005);
    chk("R9 freq kept", voiceFreq[0], 16'h1234);
    chk("R9 cutoff kept", {5'h0, cutoff}, 16'h055F);
    doRead(5'h05, q); chk("R9 bus refreshed", {8'h0, q}, 16'h003C);

    // R8 simultaneous read and write
    doWrite(5'h06, 8'h11);
    @(negedge clk);
    addr = 5'h1D; wrData = 8'h77; wrEn = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    chk("R8 read before write", {8'h0, rdData}, 16'h0011);
    repeat (2) @(negedge clk);
    chk("R8 rdData holds", {8'h0, rdData}, 16'h0011);
    doRead(5'h1D, q); chk("R8 later read", {8'h0, q}, 16'h0077);

    // R7 aging
    doWrite(5'h00, 8'hA5);
    age(LIFE - 1);
    doRead(5'h00, q); chk("R7 before expiry", {8'h0, q}, 16'h00A5);
    age(1);
    doRead(5'h00, q); chk("R7 expired", {8'h0, q}, 16'h0);
    // R7 write wins over cycleEn
    @(negedge clk);
    addr = 5'h1D; wrData = 8'h66; wrEn = 1'b1; cycleEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    repeat (LIFE - 2) @(negedge clk);
    cycleEn = 1'b0;
    doRead(5'h1D, q); chk("R7 write beats enable", {8'h0, q}, 16'h0066);

    // R10 sync ring (voice1 ctrl already has sync bit clear: 0x41)
    doWrite(5'h0B, 8'h02);
    msbRise = 3'b001; #1;
    chk("R10 voice0 syncs voice1", {13'h0, syncReset}, 16'h0002);
    doWrite(5'h04, 8'h02);
    msbRise = 3'b101; #1;
    chk("R10 source itself synced", {13'h0, syncReset}, 16'h0001);
    msbRise = 3'b100; #1;
    chk("R10 voice2 syncs voice0", {13'h0, syncReset}, 16'h0001);
    msbRise = 3'b000;

    finish_run();
  end
endmodule